// File: doc/BRIEF.md
# Prioritized Local-to-PCI Address Window Translator

This block sits on the local-bus side of a host bridge and turns each local address into a PCI bus address. Three programmable windows cover the local address space. Two are general windows with a programmable size from 1 MB to 2 GB. The third is a fixed 16 MB window that always issues I/O cycles. Every window has a base register, which chooses which local addresses it claims, and a map register, which supplies the upper PCI address bits and the cycle attributes.

Windows may overlap. The windows are searched from the lowest index upward, and the first enabled window that claims the address supplies the translation. Software uses this to reuse a window. It first enlarges window 0 so that it covers the range of window 1. Window 1 can then be reprogrammed, for example for configuration cycles, without disturbing memory traffic. The lookup is combinational from the address, and one register stage holds the result. A narrow register port with a select code sets up the windows and reads them back.

Top module: `addr_window_xlate`

## Requirements
- R1: After reset, every window is disabled and all register readbacks are zero. The outputs `xl_hit`, `xl_addr`, `xl_ctype` and `xl_adlow` are zero, and no address hits.
- R2: A general window (0 or 1) takes the following fields from its base register. Bits 31:20 give the base page. Bits 7:4 give the size code n, which means 2^(20+n) bytes (0 is 1 MB, 11 is 2 GB). Bit 0 is the enable. An address matches when its bits above the window size equal the base bits above the window size.
- R3: A hit on a general window gives the following outputs. The PCI address bits above the window size come from map bits 15:4, aligned to PCI bit 20. The address bits below the window size pass through unchanged. `xl_ctype` is map bits 3:1, and `xl_adlow` is map bit 0. Cycle type codes: interrupt acknowledge 000, I/O 001, memory 011, configuration 101, memory-multiple 110.
- R4: Window 2 is enabled by base bit 0. It matches when local bits 31:24 equal base bits 15:8. Its PCI address is map bits 15:8 followed by local bits 23:0. Its cycle type is 001 and its `xl_adlow` is 0.
- R5: When several windows match, the lowest-numbered enabled window that matches supplies the translation.
- R6: When window 0 is enlarged from 256 MB to 512 MB, it hides an enabled window 1 across the overlapping range.
- R7: A general window with size code 12 to 15 never matches, even when its enable bit is set.
- R8: The miss case drives `xl_hit` low and all other outputs to zero. A miss occurs when `la_valid` is low or when no window matches.
- R9: The result of a translation appears on the outputs in the cycle after `la_valid` is sampled. A register write made in the same cycle as a translation does not affect that translation. It does affect the next one.
- R10: Register select codes are: 0 base of window 0, 1 map of window 0, 2 base of window 1, 3 map of window 1, 4 base of window 2, 5 map of window 2. Only the defined fields are stored. Undefined bits read as zero. Selects 6 and 7 read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register readback of the selected register (combinational) |
| la_valid | input | 1 | Local address valid |
| la_addr | input | 32 | Local bus address |
| xl_hit | output | 1 | A window claimed the registered address |
| xl_addr | output | 32 | Translated PCI address |
| xl_ctype | output | 3 | PCI cycle type |
| xl_adlow | output | 1 | Pass-through enable for PCI address bits 1:0 |

## Verification
Some properties are checked on every cycle against the match outputs of the individual windows. Window 0 always wins when it matches. A sole match on the I/O window yields cycle type 001 with the low 24 bits passed through. Every hit keeps the low 20 address bits. Every miss or idle cycle is quiet on all outputs. Other behaviour needs programmed scenarios from the bench and cannot be seen by those per-cycle checks. This covers the size encoding at 256 MB, 512 MB and 2 GB. It also covers disabling by out-of-range size codes, the enlarged window 0 hiding window 1, and the same-cycle write that must not reach the translation already under way. The bench also checks register readback masking and ignored select codes.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int AW       = 32;
    localparam int PAGE_LSB = 20;
    localparam int PG_W     = AW - PAGE_LSB;
    localparam int IO_LSB   = 24;
    localparam int IO_W     = AW - IO_LSB;
    localparam int IO_SIZE  = IO_LSB - PAGE_LSB;
    localparam int SIZE_MAX = 11;
    localparam int NGEN     = 2;
    localparam int NWIN     = NGEN + 1;

    typedef enum logic [2:0] {
        CT_IACK = 3'b000,
        CT_IO   = 3'b001,
        CT_MEM  = 3'b011,
        CT_CFG  = 3'b101,
        CT_MEMM = 3'b110
    } ctype_e;

    typedef struct packed {
        logic [PG_W-1:0] page;
        logic [3:0]      size;
        logic            en;
        logic [PG_W-1:0] mpage;
        logic [2:0]      ct;
        logic            adl;
    } gen_win_s;

    typedef struct packed {
        logic [IO_W-1:0] page;
        logic            en;
        logic [IO_W-1:0] mpage;
    } io_win_s;

    typedef struct packed {
        gen_win_s [NGEN-1:0] gen;
        io_win_s             io;
    } win_cfg_s;

    typedef struct packed {
        logic          hit;
        logic [AW-1:0] addr;
        logic [2:0]    ctype;
        logic          adlow;
    } xl_out_s;
endpackage

// File: rtl/xlate_win_regs.sv
module xlate_win_regs
    import xlate_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    output win_cfg_s      cfg_q
);
    win_cfg_s cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            unique case (cfg_sel)
                3'd0, 3'd2: begin
                    cfg_d.gen[cfg_sel[1]].page = cfg_wdata[AW-1:PAGE_LSB];
                    cfg_d.gen[cfg_sel[1]].size = cfg_wdata[7:4];
                    cfg_d.gen[cfg_sel[1]].en   = cfg_wdata[0];
                end
                3'd1, 3'd3: begin
                    cfg_d.gen[cfg_sel[1]].mpage = cfg_wdata[15:4];
                    cfg_d.gen[cfg_sel[1]].ct    = cfg_wdata[3:1];
                    cfg_d.gen[cfg_sel[1]].adl   = cfg_wdata[0];
                end
                3'd4: begin
                    cfg_d.io.page = cfg_wdata[15:8];
                    cfg_d.io.en   = cfg_wdata[0];
                end
                3'd5: cfg_d.io.mpage = cfg_wdata[15:8];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        unique case (cfg_sel)
            3'd0, 3'd2: cfg_rdata = {cfg_q.gen[cfg_sel[1]].page, 12'h000,
                                     cfg_q.gen[cfg_sel[1]].size, 3'b000,
                                     cfg_q.gen[cfg_sel[1]].en};
            3'd1, 3'd3: cfg_rdata = {16'h0000, cfg_q.gen[cfg_sel[1]].mpage,
                                     cfg_q.gen[cfg_sel[1]].ct,
                                     cfg_q.gen[cfg_sel[1]].adl};
            3'd4:       cfg_rdata = {16'h0000, cfg_q.io.page, 7'b0000000, cfg_q.io.en};
            3'd5:       cfg_rdata = {16'h0000, cfg_q.io.mpage, 8'h00};
            default:    cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/xlate_win_match.sv
module xlate_win_match
    import xlate_pkg::*;
(
    input  logic [AW-1:0]   la_addr,
    input  logic            en,
    input  logic [PG_W-1:0] page,
    input  logic [3:0]      size,
    input  logic [PG_W-1:0] mpage,
    input  logic [2:0]      ct,
    input  logic            adl,
    output logic            hit,
    output logic [AW-1:0]   xaddr,
    output logic [2:0]      ctype,
    output logic            adlow
);
    localparam logic [AW-1:0] ONE = 1;

    logic [AW-1:0] lo_mask;
    logic [AW-1:0] base_full;
    logic [AW-1:0] map_full;
    logic          size_ok;

    always_comb begin
        size_ok   = (size <= 4'(SIZE_MAX));
        lo_mask   = (ONE << (PAGE_LSB + int'(size))) - ONE;
        base_full = {page, {PAGE_LSB{1'b0}}};
        map_full  = {mpage, {PAGE_LSB{1'b0}}};
        hit       = en && size_ok &&
                    ((la_addr & ~lo_mask) == (base_full & ~lo_mask));
        xaddr     = (map_full & ~lo_mask) | (la_addr & lo_mask);
        ctype     = ct;
        adlow     = adl;
    end
endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
    import xlate_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    input  logic          la_valid,
    input  logic [AW-1:0] la_addr,
    output logic          xl_hit,
    output logic [AW-1:0] xl_addr,
    output logic [2:0]    xl_ctype,
    output logic          xl_adlow
);
    win_cfg_s cfg_q;

    logic [NWIN-1:0]           match_w;
    logic [NWIN-1:0][AW-1:0]   xaddr_w;
    logic [NWIN-1:0][2:0]      ctype_w;
    logic [NWIN-1:0]           adlow_w;

    xl_out_s out_d, out_q;

    xlate_win_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_q     (cfg_q)
    );

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        if (i < NGEN) begin : g_gen
            xlate_win_match match_i (
                .la_addr (la_addr),
                .en      (cfg_q.gen[i].en),
                .page    (cfg_q.gen[i].page),
                .size    (cfg_q.gen[i].size),
                .mpage   (cfg_q.gen[i].mpage),
                .ct      (cfg_q.gen[i].ct),
                .adl     (cfg_q.gen[i].adl),
                .hit     (match_w[i]),
                .xaddr   (xaddr_w[i]),
                .ctype   (ctype_w[i]),
                .adlow   (adlow_w[i])
            );
        end else begin : g_io
            xlate_win_match match_i (
                .la_addr (la_addr),
                .en      (cfg_q.io.en),
                .page    ({cfg_q.io.page, {IO_SIZE{1'b0}}}),
                .size    (4'(IO_SIZE)),
                .mpage   ({cfg_q.io.mpage, {IO_SIZE{1'b0}}}),
                .ct      (CT_IO),
                .adl     (1'b0),
                .hit     (match_w[i]),
                .xaddr   (xaddr_w[i]),
                .ctype   (ctype_w[i]),
                .adlow   (adlow_w[i])
            );
        end
    end

    always_comb begin
        out_d = '0;
        if (la_valid) begin
            for (int i = NWIN - 1; i >= 0; i--) begin
                if (match_w[i]) begin
                    out_d.hit   = 1'b1;
                    out_d.addr  = xaddr_w[i];
                    out_d.ctype = ctype_w[i];
                    out_d.adlow = adlow_w[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign xl_hit   = out_q.hit;
    assign xl_addr  = out_q.addr;
    assign xl_ctype = out_q.ctype;
    assign xl_adlow = out_q.adlow;
endmodule

// File: rtl/addr_window_xlate_chk.sv
module addr_window_xlate_chk
    import xlate_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    la_valid,
    input logic [AW-1:0]           la_addr,
    input logic                    xl_hit,
    input logic [AW-1:0]           xl_addr,
    input logic [2:0]              xl_ctype,
    input logic                    xl_adlow,
    input logic [NWIN-1:0]         match_w,
    input logic [NWIN-1:0][AW-1:0] xaddr_w
);
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_hit |-> (xl_addr == '0 && xl_ctype == 3'b000 && !xl_adlow)); // R8

    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !la_valid |=> !xl_hit); // R8

    AST_NO_MATCH_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (la_valid && match_w == '0) |=> !xl_hit); // R8

    AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        la_valid |=> (!xl_hit || xl_addr[PAGE_LSB-1:0] == $past(la_addr[PAGE_LSB-1:0]))); // R3

    AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (la_valid && match_w[0]) |=> (xl_hit && xl_addr == $past(xaddr_w[0]))); // R5

    AST_IO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (la_valid && match_w == 3'b100) |=>
        (xl_ctype == 3'b001 && !xl_adlow && xl_addr[23:0] == $past(la_addr[23:0]))); // R4
endmodule

bind addr_window_xlate addr_window_xlate_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .la_valid (la_valid),
    .la_addr  (la_addr),
    .xl_hit   (xl_hit),
    .xl_addr  (xl_addr),
    .xl_ctype (xl_ctype),
    .xl_adlow (xl_adlow),
    .match_w  (match_w),
    .xaddr_w  (xaddr_w)
);

// File: tb/addr_window_xlate_tb_top.sv
module addr_window_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        la_valid = 1'b0;
    logic [31:0] la_addr = '0;
    logic        xl_hit;
    logic [31:0] xl_addr;
    logic [2:0]  xl_ctype;
    logic        xl_adlow;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    addr_window_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .la_valid(la_valid),
        .la_addr(la_addr), .xl_hit(xl_hit), .xl_addr(xl_addr),
        .xl_ctype(xl_ctype), .xl_adlow(xl_adlow)
    );

    localparam int NV = 8;
    localparam logic [NV-1:0] V_VALID = 8'b0111_1111;
    localparam logic [31:0] V_ADDR [NV] = '{
        32'h4123_4567, 32'h5ABC_DEF0, 32'h6012_3456, 32'h6112_3456,
        32'h3FFF_FFFF, 32'h4FFF_FFFF, 32'h5000_0000, 32'h4123_4567};
    localparam logic [36:0] V_EXP [NV] = '{
        {1'b1, 32'h0123_4567, 3'b011, 1'b0},
        {1'b1, 32'h9ABC_DEF0, 3'b011, 1'b0},
        {1'b1, 32'hAB12_3456, 3'b001, 1'b0},
        37'd0, 37'd0,
        {1'b1, 32'h0FFF_FFFF, 3'b011, 1'b0},
        {1'b1, 32'h9000_0000, 3'b011, 1'b0},
        37'd0};

    task automatic cmp(input string tag, input logic [36:0] act, input logic [36:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] sel, input logic [31:0] exp);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        cmp(tag, {5'd0, cfg_rdata}, {5'd0, exp});
    endtask

    task automatic xl_chk(input string tag, input logic v, input logic [31:0] a,
                          input logic [36:0] exp);
        @(negedge clk);
        la_valid = v; la_addr = a;
        @(posedge clk);
        #1;
        cmp(tag, {xl_hit, xl_addr, xl_ctype, xl_adlow}, exp);
        @(negedge clk);
        la_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        cmp("R1 outputs", {xl_hit, xl_addr, xl_ctype, xl_adlow}, 37'd0);
        for (int s = 0; s < 6; s++) rd_chk("R1 readback", 3'(s), 32'd0);
        xl_chk("R1 no hit", 1'b1, 32'h4123_4567, 37'd0);

        // baseline programming
        wr(3'd0, 32'h4000_0081);
        wr(3'd1, 32'h0000_0006);
        wr(3'd2, 32'h5000_0081);
        wr(3'd3, 32'h0000_9006);
        wr(3'd4, 32'h0000_6001);
        wr(3'd5, 32'h0000_AB00);

        // R2 R3 R4 R8: vector table
        for (int i = 0; i < NV; i++)
            xl_chk("R2/R3/R4/R8 vector", V_VALID[i], V_ADDR[i], V_EXP[i]);

        // R6: enlarge window 0 to 512 MB, hides window 1
        wr(3'd0, 32'h4000_0091);
        xl_chk("R6 hide", 1'b1, 32'h5ABC_DEF0, {1'b1, 32'h1ABC_DEF0, 3'b011, 1'b0});

        // R3: config window with low address enable
        wr(3'd2, 32'h6100_0041);
        wr(3'd3, 32'h0000_000B);
        xl_chk("R3 cfg", 1'b1, 32'h6100_0800, {1'b1, 32'h0000_0800, 3'b101, 1'b1});

        // R5: window 1 overlaps window 2 and wins
        wr(3'd2, 32'h6000_0041);
        wr(3'd3, 32'h0000_3006);
        xl_chk("R5 prio", 1'b1, 32'h6012_3456, {1'b1, 32'h3012_3456, 3'b011, 1'b0});

        // R9: write in the same cycle as a translation
        @(negedge clk);
        la_valid = 1'b1; la_addr = 32'h6012_3456;
        cfg_we = 1'b1; cfg_sel = 3'd2; cfg_wdata = 32'd0;
        @(posedge clk);
        #1;
        cmp("R9 old cfg", {xl_hit, xl_addr, xl_ctype, xl_adlow}, {1'b1, 32'h3012_3456, 3'b011, 1'b0});
        @(negedge clk);
        cfg_we = 1'b0;
        @(posedge clk);
        #1;
        cmp("R9 new cfg", {xl_hit, xl_addr, xl_ctype, xl_adlow}, {1'b1, 32'hAB12_3456, 3'b001, 1'b0});
        @(negedge clk);
        la_valid = 1'b0;

        // R7: size code 12 disables window
        wr(3'd0, 32'h4000_00C1);
        rd_chk("R7 readback", 3'd0, 32'h4000_00C1);
        xl_chk("R7 disabled", 1'b1, 32'h4123_4567, 37'd0);

        // R2: 2 GB window edge
        wr(3'd0, 32'h8000_00B1);
        xl_chk("R2 2GB in", 1'b1, 32'hFFFF_0000, {1'b1, 32'h7FFF_0000, 3'b011, 1'b0});
        xl_chk("R2 2GB out", 1'b1, 32'h7FFF_FFFF, 37'd0);

        // R10: register port masking and ignored selects
        wr(3'd0, 32'hFFFF_FFFF);
        rd_chk("R10 base mask", 3'd0, 32'hFFF0_00F1);
        wr(3'd6, 32'h1234_5678);
        rd_chk("R10 sel6", 3'd6, 32'd0);
        rd_chk("R10 map2", 3'd5, 32'h0000_AB00);
        rd_chk("R10 map1", 3'd3, 32'h0000_3006);
        rd_chk("R10 base2", 3'd4, 32'h0000_6001);
        xl_chk("R10 unaffected", 1'b1, 32'h6012_3456, {1'b1, 32'hAB12_3456, 3'b001, 1'b0});

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule